// File: doc/BRIEF.md
# SD/MMC Host Interrupt Status Collector

This block sits beside the command and data engines of an SD/MMC host controller. Each engine reports events as single-cycle pulses on a 32-bit event vector. The block holds every pulse in a sticky raw status register. A programmable enable mask selects which raw bits reach a masked status view, and one interrupt line is raised from that view. The line is gated by a master enable bit in a control word.

Software clears a serviced event by writing a one to its position in the raw status register. It reads the masked view to find out why the line is high. Two summary outputs tell the host core whether any enabled error event, or any enabled completion event, is pending. The host core can then stop a transfer early or close it normally. The register port is a plain write strobe with address and data. Its read data is combinational from the address.

Top module: `sdmmc_irq_status`

## Requirements
- R1: After reset the control word, the mask and the raw status all read zero, and irq_o, err_any_o and done_any_o are low.
- R2: An event pulse on a defined position sets that raw bit at the next clock edge. The bit then stays set until software clears it. Defined positions are 1 to 16, 30 and 31.
- R3: Positions 0 and 17 to 29 are undefined. They never become set in raw status, whatever the event pulse, and they always read zero in the mask.
- R4: A write to offset 0x38 clears every raw bit where the write data holds a one. Bits where the write data holds a zero keep their value.
- R5: When an event pulse and a clear for the same raw bit arrive in one cycle, the bit ends up set.
- R6: Offset 0x34 reads raw status ANDed with the mask, and it follows raw status changes in the same cycle. Writes to 0x34 have no effect.
- R7: irq_o is high exactly when the enable bit is set and at least one masked status bit is set.
- R8: The enable bit sits at bit 4 of the control word at offset 0x00. It is written there and read back there, and every other control bit reads zero.
- R9: err_any_o is high when a masked status bit is set at any of positions 1, 6, 7, 8, 9, 11, 12, 13 or 15.
- R10: done_any_o is high when a masked status bit is set at any of positions 2, 3, 10 or 14.
- R11: A write to offset 0x30 loads the mask from the write data, limited to the defined positions, and the mask reads back at 0x30.
- R12: Any offset other than 0x00, 0x30, 0x34 and 0x38 reads zero, and writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | 32 | Single-cycle event pulses from the host core, one per status position |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| irq_o | output | 1 | Interrupt line |
| err_any_o | output | 1 | An enabled error event is pending |
| done_any_o | output | 1 | An enabled completion event is pending |

## Verification
The bench pulses an event and clears the same bit in one cycle. A design that let the clear win would lose an event that arrived while software was servicing the previous one. It writes zeros to the raw register and all-ones to the masked view and to an unmapped offset. A design with a plain write instead of write-one-to-clear, or with a loose address decode, would corrupt or wipe the status. It drives pulses on the undefined positions and toggles the enable bit with masked bits pending, which exposes stray status bits and an ungated interrupt line. It also moves the mask between the error and completion groups, which exposes a summary wired to the wrong group or taken from unmasked status.

// File: rtl/isu_pkg.sv
package isu_pkg;

    localparam int DATA_W = 32;
    localparam int ADDR_W = 8;

    // register offsets
    localparam logic [ADDR_W-1:0] OFS_CTL   = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_MASK  = 8'h30;
    localparam logic [ADDR_W-1:0] OFS_MSTAT = 8'h34;
    localparam logic [ADDR_W-1:0] OFS_RAW   = 8'h38;

    localparam int CTL_EN_BIT = 4;

    // event positions
    localparam int EV_RSP_ERR   = 1;
    localparam int EV_CMD_DONE  = 2;
    localparam int EV_DAT_OVER  = 3;
    localparam int EV_TX_REQ    = 4;
    localparam int EV_RX_REQ    = 5;
    localparam int EV_RSP_CRC   = 6;
    localparam int EV_DAT_CRC   = 7;
    localparam int EV_RSP_TO    = 8;
    localparam int EV_DAT_TO    = 9;
    localparam int EV_VSW_DONE  = 10;
    localparam int EV_FIFO_ERR  = 11;
    localparam int EV_HW_LOCK   = 12;
    localparam int EV_SBIT_ERR  = 13;
    localparam int EV_ACMD_DONE = 14;
    localparam int EV_EBIT_ERR  = 15;
    localparam int EV_SDIO      = 16;
    localparam int EV_CARD_IN   = 30;
    localparam int EV_CARD_OUT  = 31;

    localparam logic [DATA_W-1:0] ONE = {{(DATA_W-1){1'b0}}, 1'b1};

    localparam logic [DATA_W-1:0] ERR_GROUP =
        (ONE << EV_RSP_ERR)  | (ONE << EV_RSP_CRC)  | (ONE << EV_DAT_CRC) |
        (ONE << EV_RSP_TO)   | (ONE << EV_DAT_TO)   | (ONE << EV_FIFO_ERR) |
        (ONE << EV_HW_LOCK)  | (ONE << EV_SBIT_ERR) | (ONE << EV_EBIT_ERR);

    localparam logic [DATA_W-1:0] DONE_GROUP =
        (ONE << EV_CMD_DONE) | (ONE << EV_DAT_OVER) |
        (ONE << EV_VSW_DONE) | (ONE << EV_ACMD_DONE);

    localparam logic [DATA_W-1:0] VALID_MASK =
        ERR_GROUP | DONE_GROUP | (ONE << EV_TX_REQ) | (ONE << EV_RX_REQ) |
        (ONE << EV_SDIO) | (ONE << EV_CARD_IN) | (ONE << EV_CARD_OUT);

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_CTL,
        SEL_MASK,
        SEL_MSTAT,
        SEL_RAW
    } reg_sel_e;

    typedef struct packed {
        logic [DATA_W-1:0] raw;
    } stat_state_t;

    typedef struct packed {
        logic              en;
        logic [DATA_W-1:0] mask;
    } ctrl_state_t;

endpackage

// File: rtl/isu_reg_port.sv
module isu_reg_port
    import isu_pkg::*;
(
    input  logic              wen_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              en_i,
    input  logic [DATA_W-1:0] mask_i,
    input  logic [DATA_W-1:0] masked_i,
    input  logic [DATA_W-1:0] raw_i,
    output logic              wr_ctl_o,
    output logic              wr_mask_o,
    output logic [DATA_W-1:0] clr_o,
    output logic [DATA_W-1:0] rdata_o
);

    reg_sel_e sel;

    always_comb begin
        unique case (addr_i)
            OFS_CTL:   sel = SEL_CTL;
            OFS_MASK:  sel = SEL_MASK;
            OFS_MSTAT: sel = SEL_MSTAT;
            OFS_RAW:   sel = SEL_RAW;
            default:   sel = SEL_NONE;
        endcase
    end

    always_comb begin
        wr_ctl_o  = wen_i && (sel == SEL_CTL);
        wr_mask_o = wen_i && (sel == SEL_MASK);
        clr_o     = (wen_i && (sel == SEL_RAW)) ? wdata_i : '0;
    end

    always_comb begin
        rdata_o = '0;
        case (sel)
            SEL_CTL:   rdata_o[CTL_EN_BIT] = en_i;
            SEL_MASK:  rdata_o = mask_i;
            SEL_MSTAT: rdata_o = masked_i;
            SEL_RAW:   rdata_o = raw_i;
            default:   rdata_o = '0;
        endcase
    end

    // R6, R12: writes to the masked view or unmapped offsets produce no strobe
    always_comb begin
        if (wen_i && (sel == SEL_MSTAT || sel == SEL_NONE)) begin
            a_ro_nostrobe_r12: assert (!wr_ctl_o && !wr_mask_o && clr_o == '0)
                else $error("write to read-only or unmapped offset produced a strobe");
        end
    end

endmodule

// File: rtl/isu_ctrl_regs.sv
module isu_ctrl_regs
    import isu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ctl_i,
    input  logic              wr_mask_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic              en_o,
    output logic [DATA_W-1:0] mask_o
);

    ctrl_state_t ctl_d, ctl_q;

    always_comb begin
        ctl_d = ctl_q;
        if (wr_ctl_i) begin
            ctl_d.en = wdata_i[CTL_EN_BIT];
        end
        if (wr_mask_i) begin
            ctl_d.mask = wdata_i & VALID_MASK;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign en_o   = ctl_q.en;
    assign mask_o = ctl_q.mask;

    // R11: a mask write lands on the next edge, limited to defined positions
    p_mask_load_r11: assert property (@(posedge clk) disable iff (!rst_n)
        wr_mask_i |=> (mask_o == ($past(wdata_i) & VALID_MASK)));

    // R8: the enable bit only moves on a control write
    p_en_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_ctl_i |=> $stable(en_o));

endmodule

// File: rtl/isu_status_core.sv
module isu_status_core
    import isu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] evt_i,
    input  logic [DATA_W-1:0] clr_i,
    output logic [DATA_W-1:0] raw_o
);

    stat_state_t st_d, st_q;
    logic [DATA_W-1:0] nxt;

    for (genvar gi = 0; gi < DATA_W; gi++) begin : g_bit
        // undefined positions are tied low; defined ones are sticky, event beats clear
        assign nxt[gi] = VALID_MASK[gi] ? (evt_i[gi] | (st_q.raw[gi] & ~clr_i[gi])) : 1'b0;
    end

    always_comb begin
        st_d     = st_q;
        st_d.raw = nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign raw_o = st_q.raw;

    // R2: a defined event pulse is captured on the next edge
    p_evt_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        |(evt_i & VALID_MASK) |=>
        ((raw_o & $past(evt_i & VALID_MASK)) == $past(evt_i & VALID_MASK)));

    // R2: with no clear, no bit falls
    p_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i == '0) |=> (($past(raw_o) & ~raw_o) == '0));

    // R4: cleared bits without a coincident event read zero next cycle
    p_w1c_r4: assert property (@(posedge clk) disable iff (!rst_n)
        |(clr_i & ~evt_i) |=> ((raw_o & $past(clr_i & ~evt_i)) == '0));

    // R5: event and clear together leave the bit set
    p_evt_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
        |(clr_i & evt_i & VALID_MASK) |=>
        ((raw_o & $past(clr_i & evt_i & VALID_MASK)) == $past(clr_i & evt_i & VALID_MASK)));

endmodule

// File: rtl/isu_irq_summary.sv
module isu_irq_summary
    import isu_pkg::*;
(
    input  logic              en_i,
    input  logic [DATA_W-1:0] raw_i,
    input  logic [DATA_W-1:0] mask_i,
    output logic [DATA_W-1:0] masked_o,
    output logic              irq_o,
    output logic              err_o,
    output logic              done_o
);

    always_comb begin
        masked_o = raw_i & mask_i;
        err_o    = |(masked_o & ERR_GROUP);
        done_o   = |(masked_o & DONE_GROUP);
        irq_o    = en_i & (|masked_o);
    end

    // R7: no interrupt while the master enable is off
    always_comb begin
        if (!en_i) begin
            a_gate_r7: assert (!irq_o) else $error("irq without enable");
        end
    end

endmodule

// File: rtl/sdmmc_irq_status.sv
module sdmmc_irq_status
    import isu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] evt_i,
    input  logic              reg_wen,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq_o,
    output logic              err_any_o,
    output logic              done_any_o
);

    logic              wr_ctl;
    logic              wr_mask;
    logic [DATA_W-1:0] clr_vec;
    logic              en;
    logic [DATA_W-1:0] mask;
    logic [DATA_W-1:0] raw;
    logic [DATA_W-1:0] masked;

    isu_reg_port u_port (
        .wen_i    (reg_wen),
        .addr_i   (reg_addr),
        .wdata_i  (reg_wdata),
        .en_i     (en),
        .mask_i   (mask),
        .masked_i (masked),
        .raw_i    (raw),
        .wr_ctl_o (wr_ctl),
        .wr_mask_o(wr_mask),
        .clr_o    (clr_vec),
        .rdata_o  (reg_rdata)
    );

    isu_ctrl_regs u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_ctl_i (wr_ctl),
        .wr_mask_i(wr_mask),
        .wdata_i  (reg_wdata),
        .en_o     (en),
        .mask_o   (mask)
    );

    isu_status_core u_stat (
        .clk  (clk),
        .rst_n(rst_n),
        .evt_i(evt_i),
        .clr_i(clr_vec),
        .raw_o(raw)
    );

    isu_irq_summary u_sum (
        .en_i    (en),
        .raw_i   (raw),
        .mask_i  (mask),
        .masked_o(masked),
        .irq_o   (irq_o),
        .err_o   (err_any_o),
        .done_o  (done_any_o)
    );

    // R7: the line tracks enable and masked state held in separate registers
    p_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == (en && ((raw & mask) != '0)));

    // R3: status and mask reads never show undefined positions
    p_undef_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == OFS_RAW || reg_addr == OFS_MASK) |-> ((reg_rdata & ~VALID_MASK) == '0));

    // R6: writing the masked view leaves raw status untouched unless an event arrives
    p_mstat_ro_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wen && reg_addr == OFS_MSTAT && evt_i == '0) |=> $stable(raw));

endmodule

// File: tb/sdmmc_irq_status_bench.sv
`timescale 1ns/1ps
module sdmmc_irq_status_bench;

    localparam logic [31:0] VALID = 32'hC001_FFFE;
    localparam logic [31:0] ERRG  = 32'h0000_BBC2;
    localparam logic [31:0] DONEG = 32'h0000_440C;
    localparam logic [7:0]  A_CTL = 8'h00, A_MSK = 8'h30, A_MST = 8'h34, A_RAW = 8'h38;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] evt_i = '0;
    logic        reg_wen = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq_o, err_any_o, done_any_o;

    int total = 0;
    int bad = 0;

    logic [31:0] m_raw = '0;
    logic [31:0] m_mask = '0;
    logic        m_en = 1'b0;

    always #2.5 clk = ~clk;

    sdmmc_irq_status u_sdmmc_irq_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_i     (evt_i),
        .reg_wen   (reg_wen),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq_o     (irq_o),
        .err_any_o (err_any_o),
        .done_any_o(done_any_o)
    );

    function automatic logic [31:0] exp_rd(input logic [7:0] a);
        case (a)
            A_CTL:   return {27'b0, m_en, 4'b0};
            A_MSK:   return m_mask;
            A_MST:   return m_raw & m_mask;
            A_RAW:   return m_raw;
            default: return 32'h0;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic chk_outs();
        chk("R7 irq", {31'b0, irq_o}, {31'b0, m_en && ((m_raw & m_mask) != 0)});
        chk("R9 err", {31'b0, err_any_o}, {31'b0, ((m_raw & m_mask & ERRG) != 0)});
        chk("R10 done", {31'b0, done_any_o}, {31'b0, ((m_raw & m_mask & DONEG) != 0)});
    endtask

    task automatic step(input logic [31:0] ev, input logic we, input logic [7:0] ad,
                        input logic [31:0] wd);
        logic [31:0] clr;
        @(negedge clk);
        evt_i = ev; reg_wen = we; reg_addr = ad; reg_wdata = wd;
        @(posedge clk);
        clr = (we && ad == A_RAW) ? wd : 32'h0;
        m_raw = ((m_raw & ~clr) | ev) & VALID;
        if (we && ad == A_MSK) m_mask = wd & VALID;
        if (we && ad == A_CTL) m_en = wd[4];
        #1;
        chk_outs();
    endtask

    task automatic rd(input logic [7:0] ad, input string tag);
        @(negedge clk);
        evt_i = '0; reg_wen = 1'b0; reg_addr = ad;
        #1;
        chk(tag, reg_rdata, exp_rd(ad));
    endtask

    initial begin
        #(200000 * 5);
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk("R1 ctl", reg_rdata, 32'h0);
        rd(A_MSK, "R1 mask"); rd(A_RAW, "R1 raw");
        chk("R1 irq", {29'b0, irq_o, err_any_o, done_any_o}, 32'h0);

        // R2 capture and hold
        step(32'h4, 1'b0, 8'h00, 32'h0);
        rd(A_RAW, "R2 set");
        step(0, 0, 0, 0); step(0, 0, 0, 0); step(0, 0, 0, 0);
        rd(A_RAW, "R2 hold"); chk("R2 hold literal", reg_rdata, 32'h4);

        // R3 undefined positions
        step(32'h3FFE_0001, 1'b0, 8'h00, 32'h0);
        rd(A_RAW, "R3 raw"); chk("R3 raw literal", reg_rdata, 32'h4);
        step(0, 1'b1, A_MSK, 32'hFFFF_FFFF);
        rd(A_MSK, "R11 mask"); chk("R3 mask literal", reg_rdata, 32'hC001_FFFE);

        // R4 write-one-to-clear
        step(32'h10A, 0, 0, 0);
        step(0, 1'b1, A_RAW, 32'h6);
        rd(A_RAW, "R4 clear"); chk("R4 clear literal", reg_rdata, 32'h108);
        step(0, 1'b1, A_RAW, 32'h0);
        rd(A_RAW, "R4 zero keeps"); chk("R4 zero literal", reg_rdata, 32'h108);

        // R5 event beats clear
        step(32'h100, 1'b1, A_RAW, 32'h100);
        rd(A_RAW, "R5 evt wins"); chk("R5 literal", reg_rdata, 32'h108);

        // R6 masked view, read-only
        step(0, 1'b1, A_MSK, 32'h100);
        rd(A_MST, "R6 masked"); chk("R6 literal", reg_rdata, 32'h100);
        step(0, 1'b1, A_MST, 32'hFFFF_FFFF);
        rd(A_MST, "R6 ro masked"); rd(A_RAW, "R6 ro raw"); rd(A_MSK, "R6 ro mask");

        // R7 / R8 enable gating
        chk("R7 off", {31'b0, irq_o}, 32'h0);
        step(0, 1'b1, A_CTL, 32'hFFFF_FFFF);
        rd(A_CTL, "R8 ctl"); chk("R8 literal", reg_rdata, 32'h10);
        chk("R7 on", {31'b0, irq_o}, 32'h1);
        step(0, 1'b1, A_MSK, 32'h0);
        chk("R7 masked off", {31'b0, irq_o}, 32'h0);

        // R9 / R10 summaries
        step(0, 1'b1, A_RAW, 32'hFFFF_FFFF);
        step(0, 1'b1, A_MSK, 32'hFFFF_FFFF);
        step(32'h4000, 0, 0, 0);
        chk("R10 done only", {30'b0, err_any_o, done_any_o}, 32'h1);
        step(32'h40, 0, 0, 0);
        chk("R9 err", {30'b0, err_any_o, done_any_o}, 32'h3);
        step(0, 1'b1, A_MSK, DONEG);
        chk("R9 masked err", {30'b0, err_any_o, done_any_o}, 32'h1);

        // R12 unmapped offsets
        step(0, 1'b1, 8'h3C, 32'hFFFF_FFFF);
        step(0, 1'b1, 8'h04, 32'hFFFF_FFFF);
        rd(8'h3C, "R12 rd"); rd(8'h04, "R12 rd2");
        rd(A_RAW, "R12 raw kept"); rd(A_MSK, "R12 mask kept"); rd(A_CTL, "R12 ctl kept");

        // random mix
        for (int k = 0; k < 800; k++) begin
            logic [31:0] ev;
            logic [31:0] wd;
            int op;
            ev = $urandom() & $urandom() & $urandom();
            wd = $urandom();
            op = $urandom_range(0, 5);
            case (op)
                0: step(ev, 1'b0, 8'h00, wd);
                1: step(ev, 1'b1, A_CTL, wd);
                2: step(ev, 1'b1, A_MSK, wd);
                3: step(ev, 1'b1, A_RAW, wd);
                4: step(ev, 1'b1, A_MST, wd);
                default: step(ev, 1'b1, 8'h40, wd);
            endcase
            rd(A_RAW, "R2 R4 R5 random raw");
            rd(A_MST, "R6 random masked");
            if (k % 8 == 0) begin
                rd(A_MSK, "R11 random mask");
                rd(A_CTL, "R8 random ctl");
            end
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule